// File: doc/BRIEF.md
# Acknowledge-Gated Timer Interrupt Pacer

This block sits between a periodic timer's expiry strobe and an edge-style interrupt line. It does not forward every expiry straight to the line. It keeps a count of expiries that have not yet been delivered. It then issues interrupt pulses one at a time, and it issues the next pulse only after the consumer has acknowledged the previous one. When the interrupt consumer falls behind, ticks wait in the count and are replayed later, so none are lost.

A single armed flag carries the handshake. Issuing a pulse clears the flag, and an acknowledge sets it again. An acknowledge also retires one queued tick. Unmasking the interrupt, reprogramming the timer or a reset empties the queue and re-arms the handshake. The pending count saturates at its largest value and does not wrap.

Top module: `tick_pacer`

## Requirements
- R1: Each cycle with `tick_i` high and `ack_i`, `unmask_i`, `reprog_i` low adds one to the pending count.
- R2: The pending count saturates at 2^CNT_W-1 (255 by default). Further ticks leave it unchanged, so exactly that many acknowledges are needed to drain it.
- R3: A cycle in which the count is nonzero, the armed flag is set and neither `unmask_i` nor `reprog_i` is high is a fire cycle. `irq_o` is high in the cycle after a fire cycle, and in no other cycle.
- R4: A fire cycle clears the armed flag unless `ack_i` is high in that same cycle. No further fire occurs until an acknowledge arrives.
- R5: A cycle with `ack_i` high and `tick_i`, `unmask_i`, `reprog_i` low lowers the count by one, never below zero, and sets the armed flag.
- R6: When `tick_i` and `ack_i` are both high and no clear is present, the count keeps its value and the armed flag is set.
- R7: Each fire produces a pulse on `irq_o` that lasts exactly one cycle. A second pulse can follow directly only if `ack_i` was high in the first fire cycle.
- R8: `unmask_i` high empties the count and sets the armed flag. It overrides `tick_i` and `ack_i` in the same cycle and suppresses a fire in that cycle.
- R9: `reprog_i` high has the same clearing effect as `unmask_i`.
- R10: While `rst_n` is low, and right after it rises, the count is zero, the flag is armed and `irq_o` is low.
- R11: `pending_o` is high exactly when the pending count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer expiry strobe, one per expiry |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| unmask_i | input | 1 | Interrupt line was unmasked |
| reprog_i | input | 1 | Timer was reprogrammed |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pending_o | output | 1 | Undelivered ticks are queued |

## Verification
The two pieces of internal state have different signatures at the ports. A wrong count first shows up on `pending_o`. Often it does not show at once: it may appear only many acknowledges later, when the queue drains too early or too late. A wrong armed flag shows up one cycle later on `irq_o`, as a missing, doubled or extra pulse. The reference model therefore compares both outputs on every cycle, and long drains after saturation expose off-by-one errors in the count.

// File: rtl/tick_pacer_pkg.sv
package tick_pacer_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_INC   = 2'd1,
    CNT_DEC   = 2'd2,
    CNT_CLEAR = 2'd3
  } cnt_op_e;

  // Count operation for one cycle; clear has priority, tick+ack cancel.
  function automatic cnt_op_e pick_op(input logic tick, input logic ack,
                                      input logic clr);
    cnt_op_e op;
    if (clr)               op = CNT_CLEAR;
    else if (tick && !ack) op = CNT_INC;
    else if (ack && !tick) op = CNT_DEC;
    else                   op = CNT_HOLD;
    return op;
  endfunction

  // Next value of the handshake flag.
  function automatic logic next_armed(input logic armed, input logic fire,
                                      input logic ack, input logic clr);
    logic nxt;
    if (clr || ack) nxt = 1'b1;
    else if (fire)  nxt = 1'b0;
    else            nxt = armed;
    return nxt;
  endfunction

endpackage

// File: rtl/tp_pend_ctr.sv
module tp_pend_ctr
  import tick_pacer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ack,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             nonzero
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] floor_dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  cnt_op_e op;
  assign op = pick_op(tick, ack, clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      unique case (op)
        CNT_INC:   cnt <= sat_inc(cnt);
        CNT_DEC:   cnt <= floor_dec(cnt);
        CNT_CLEAR: cnt <= '0;
        default:   cnt <= cnt;
      endcase
    end
  end

  assign nonzero = |cnt;

  AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ack && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R1
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ack && !clr && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R2
  AST_ACK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !tick && !clr && cnt == '0) |=> cnt == '0); // R5
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ack && !clr) |=> $stable(cnt)); // R6
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R8

endmodule

// File: rtl/tp_ack_gate.sv
module tp_ack_gate
  import tick_pacer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nonzero,
  input  logic ack,
  input  logic clr,
  output logic fire,
  output logic armed
);

  assign fire = nonzero && armed && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b1;
    else        armed <= next_armed(armed, fire, ack, clr);
  end

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ack && !clr) |=> !fire); // R4
  AST_ACK_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> armed); // R5
  AST_CLR_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> armed); // R8

endmodule

// File: rtl/tp_irq_pulse.sv
module tp_irq_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire;
  end

endmodule

// File: rtl/tick_pacer.sv
module tick_pacer #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ack_i,
  input  logic unmask_i,
  input  logic reprog_i,
  output logic irq_o,
  output logic pending_o
);

  logic             clr;
  logic [CNT_W-1:0] cnt;
  logic             nonzero;
  logic             fire;
  logic             armed;

  assign clr = unmask_i || reprog_i;

  tp_pend_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .ack(ack_i), .clr(clr),
    .cnt(cnt), .nonzero(nonzero)
  );

  tp_ack_gate u_gate (
    .clk(clk), .rst_n(rst_n), .nonzero(nonzero), .ack(ack_i), .clr(clr),
    .fire(fire), .armed(armed)
  );

  tp_irq_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .irq(irq_o)
  );

  assign pending_o = nonzero;

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(pending_o) && !$past(clr)); // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !$past(ack_i)) |=> !irq_o); // R7
  AST_REPROG_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    reprog_i |=> !pending_o); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> !irq_o && !pending_o && armed); // R10

endmodule

// File: tb/tick_pacer_test.sv
`timescale 1ns/1ps
module tick_pacer_test;

  localparam int CNT_W   = 8;
  localparam int CNT_TOP = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, ack_i = 1'b0, unmask_i = 1'b0, reprog_i = 1'b0;
  logic irq_o, pending_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_cnt   = 0;
  bit m_armed = 1'b1;
  bit m_irq   = 1'b0;
  int irq_seen = 0;

  always #2 clk = ~clk;

  tick_pacer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ack_i(ack_i),
    .unmask_i(unmask_i), .reprog_i(reprog_i),
    .irq_o(irq_o), .pending_o(pending_o)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, advance model, compare after the edge.
  task automatic step(input string req, input bit t, input bit a,
                      input bit u, input bit r);
    bit clr, fire;
    @(negedge clk);
    tick_i = t; ack_i = a; unmask_i = u; reprog_i = r;
    clr  = u || r;
    fire = (m_cnt != 0) && m_armed && !clr;
    if (clr) m_cnt = 0;
    else if (t && !a) m_cnt = (m_cnt < CNT_TOP) ? m_cnt + 1 : m_cnt;
    else if (a && !t) m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
    if (clr || a) m_armed = 1'b1;
    else if (fire) m_armed = 1'b0;
    m_irq = fire;
    @(posedge clk);
    #1;
    if (irq_o === 1'b1) irq_seen++;
    check(req, "irq_o", irq_o, m_irq);
    check(req, "pending_o", pending_o, m_cnt != 0);
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) step(req, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    int base;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "irq_o in reset", irq_o, 1'b0);
    check("R10", "pending_o in reset", pending_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10", "irq_o after reset", irq_o, 1'b0);
    check("R10", "pending_o after reset", pending_o, 1'b0);

    // R1 R3 R7: one tick yields one pulse
    base = irq_seen;
    step("R1", 1, 0, 0, 0);
    idle("R3", 4);
    checks++;
    if (irq_seen - base != 1) begin
      fails++;
      $display("FAIL R7 pulse count actual=%0d expected=1", irq_seen - base);
    end

    // R4: queued ticks held until acknowledged
    step("R4", 1, 0, 0, 0);
    step("R4", 1, 0, 0, 0);
    idle("R4", 5);
    // R5: each acknowledge releases the next pulse
    for (int i = 0; i < 4; i++) begin
      step("R5", 0, 1, 0, 0);
      idle("R5", 3);
    end
    // R5: acknowledges at zero do not underflow
    step("R5", 0, 1, 0, 0);
    step("R5", 0, 1, 0, 0);
    step("R5", 1, 0, 0, 0);
    idle("R5", 3);

    // R6: tick with ack in same cycle
    step("R6", 1, 0, 0, 0);
    step("R6", 1, 1, 0, 0);
    idle("R6", 3);
    step("R7", 0, 1, 0, 0);
    step("R7", 0, 1, 0, 0);
    idle("R7", 3);

    // R2: saturate, then drain exactly CNT_TOP acknowledges
    for (int i = 0; i < CNT_TOP + 40; i++) step("R2", 1, 0, 0, 0);
    for (int i = 0; i < CNT_TOP + 2; i++) step("R2", 0, 1, 0, 0);
    idle("R2", 3);

    // R8: unmask clears, overrides tick and ack
    for (int i = 0; i < 5; i++) step("R8", 1, 0, 0, 0);
    step("R8", 1, 1, 1, 0);
    idle("R8", 3);
    step("R8", 1, 0, 0, 0);
    idle("R8", 3);

    // R9: reprogram clears
    for (int i = 0; i < 6; i++) step("R9", 1, 0, 0, 0);
    step("R9", 0, 0, 0, 1);
    idle("R9", 3);
    step("R9", 1, 0, 0, 0);
    idle("R9", 2);

    // R11: mixed pattern
    seed = 32'h1ACE;
    for (int i = 0; i < 3000; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      step("R11", seed[20] | seed[21], seed[22] & seed[23],
           (seed[10:4] == 7'd3), (seed[17:11] == 7'd9));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule